// File: doc/BRIEF.md
# Hybrid Analog/PWM Brightness Encoder

This block turns brightness settings for two LED banks into the controls that drive their current sinks. The main bank receives a 5-bit brightness code. The block splits that code into two controls:

- a coarse analog current step (20%, 40%, 70% or 100% of full scale);
- a pulse-width gate with sixteen duty steps, repeating at a fixed 20 kHz.

The code-to-setting mapping is irregular. Each analog step covers a different band of duty values, so perceived brightness rises monotonically across the 32 codes. The auxiliary bank has a 2-bit code that selects one of the same four analog steps. The auxiliary bank has no pulse-width modulation.

A free-running slot timer divides the system clock into sixteen equal slots per PWM period. The default divider suits a 125 MHz clock. A new main code, or a main enable that has just risen, is taken on only at a period boundary. As a result, the gate never emits a shortened pulse. A falling enable blanks its bank on the next clock. All outputs are registered.

Top module: `hybrid_brightness_enc`

## Requirements
- R1: While reset is high, and on the first clock after it falls, `main_gate` is 0 and both level outputs are 0.
- R2: Main codes 0x00 to 0x0F select level code 0 (20% of full scale) with a duty of (code+1) slots out of 16.
- R3: Main codes 0x10 to 0x16 select level code 1 (40%) with a duty of (code-6) slots out of 16, i.e. 10 through 16.
- R4: Main codes 0x17 to 0x1C select level code 2 (70%) with a duty of (code-12) slots out of 16, i.e. 11 through 16.
- R5: Main codes 0x1D, 0x1E and 0x1F select level code 3 (100%) with duties of 13, 15 and 16 slots respectively.
- R6: One PWM period is 16 slots of `SLOT_CYCLES` clocks each. The gate is high for the first duty-many slots of each period and low for the rest; a duty of 16 keeps it high for the whole period. It changes only on slot boundaries.
- R7: A changed main code, or a main enable that has risen, takes effect only from the next period boundary. The gate and level in the current period keep their old values, and the gate rises only at the start of a period.
- R8: One clock after `main_en` is sampled low, `main_gate` is 0 and `main_lvl` is 0. They stay 0 while it remains low.
- R9: One clock after a sample, `aux_lvl` equals `aux_code` when `aux_en` is high, and 0 when it is low. The level codes are 0=20%, 1=40%, 2=70%, 3=100%. The value then stays constant while the inputs hold, with no pulse-width modulation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| main_en | input | 1 | Main bank enable |
| main_code | input | 5 | Main bank brightness code |
| aux_en | input | 1 | Auxiliary bank enable |
| aux_code | input | 2 | Auxiliary analog level code |
| main_gate | output | 1 | Main bank PWM gate |
| main_lvl | output | 2 | Main bank analog level select |
| aux_lvl | output | 2 | Auxiliary analog level select |

## Verification
After reset is released, the period boundary falls on every clock edge that is a multiple of 16·`SLOT_CYCLES`. A setting presented before such an edge appears on the outputs one edge later, and holds for exactly one period. The disable path and the auxiliary level each respond on the first edge after the input is sampled.

The bench counts rising edges from the release of reset in its own counter. It drives inputs on falling edges. It waits for the edge count to reach a boundary multiple, then samples every falling edge of the following period. Each sample is compared against a slot-by-slot expected gate and level. For the one-clock paths, the bench checks on the falling edge right after the driving edge.

// File: rtl/brt_pkg.sv
package brt_pkg;
  localparam int PWM_SLOTS = 16;
  localparam int SLOT_W    = $clog2(PWM_SLOTS);
  localparam int DUTY_W    = SLOT_W + 1;
  localparam int CODE_W    = 5;
  localparam int LVL_W     = 2;

  typedef enum logic [LVL_W-1:0] {
    LVL_20   = 2'd0,
    LVL_40   = 2'd1,
    LVL_70   = 2'd2,
    LVL_FULL = 2'd3
  } lvl_e;

  typedef struct packed {
    lvl_e              lvl;
    logic [DUTY_W-1:0] duty;
  } bank_set_t;
endpackage

// File: rtl/brt_code_map.sv
module brt_code_map
  import brt_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output bank_set_t         setting
);
  // Four analog bands, each with its own duty offset.
  always_comb begin
    setting.lvl  = LVL_20;
    setting.duty = DUTY_W'(code) + DUTY_W'(1);
    if (code >= CODE_W'(5'h1D)) begin
      setting.lvl = LVL_FULL;
      case (code)
        CODE_W'(5'h1D): setting.duty = DUTY_W'(13);
        CODE_W'(5'h1E): setting.duty = DUTY_W'(15);
        default:        setting.duty = DUTY_W'(16);
      endcase
    end else if (code >= CODE_W'(5'h17)) begin
      setting.lvl  = LVL_70;
      setting.duty = DUTY_W'(code) - DUTY_W'(12);
    end else if (code >= CODE_W'(5'h10)) begin
      setting.lvl  = LVL_40;
      setting.duty = DUTY_W'(code) - DUTY_W'(6);
    end
  end
endmodule

// File: rtl/brt_slot_timer.sv
module brt_slot_timer
  import brt_pkg::*;
#(
  parameter int SLOT_CYCLES = 391
) (
  input  logic              clk,
  input  logic              rst,
  output logic [SLOT_W-1:0] slot,
  output logic              wrap
);
  localparam int PRE_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;

  logic slot_end;

  generate
    if (SLOT_CYCLES == 1) begin : g_nodiv
      assign slot_end = 1'b1;
    end else begin : g_div
      logic [PRE_W-1:0] pre;
      always_ff @(posedge clk) begin
        if (rst) begin
          pre <= '0;
        end else if (pre == PRE_W'(SLOT_CYCLES - 1)) begin
          pre <= '0;
        end else begin
          pre <= pre + PRE_W'(1);
        end
      end
      assign slot_end = (pre == PRE_W'(SLOT_CYCLES - 1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      slot <= '0;
    end else if (slot_end) begin
      slot <= (slot == SLOT_W'(PWM_SLOTS - 1)) ? '0 : slot + SLOT_W'(1);
    end
  end

  assign wrap = slot_end && (slot == SLOT_W'(PWM_SLOTS - 1));
endmodule

// File: rtl/brt_pwm_gate.sv
module brt_pwm_gate
  import brt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wrap,
  input  logic [SLOT_W-1:0] slot,
  input  bank_set_t         setting,
  output logic              gate_q,
  output logic [LVL_W-1:0]  lvl_q
);
  bank_set_t applied;
  logic      applied_on;

  // Settings are captured only at a period wrap; a low enable clears at once.
  always_ff @(posedge clk) begin
    if (rst) begin
      applied_on <= 1'b0;
      applied    <= '0;
    end else if (!en) begin
      applied_on <= 1'b0;
    end else if (wrap) begin
      applied_on <= 1'b1;
      applied    <= setting;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= 1'b0;
      lvl_q  <= '0;
    end else begin
      gate_q <= en && applied_on && (DUTY_W'(slot) < applied.duty);
      lvl_q  <= (en && applied_on) ? applied.lvl : LVL_20;
    end
  end
endmodule

// File: rtl/hybrid_brightness_enc.sv
module hybrid_brightness_enc
  import brt_pkg::*;
#(
  parameter int SLOT_CYCLES = 391
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        main_en,
  input  logic [4:0]  main_code,
  input  logic        aux_en,
  input  logic [1:0]  aux_code,
  output logic        main_gate,
  output logic [1:0]  main_lvl,
  output logic [1:0]  aux_lvl
);
  logic [SLOT_W-1:0] slot;
  logic              wrap;
  bank_set_t         main_set;

  brt_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .slot (slot),
    .wrap (wrap)
  );

  brt_code_map u_map (
    .code    (main_code),
    .setting (main_set)
  );

  brt_pwm_gate u_gate (
    .clk     (clk),
    .rst     (rst),
    .en      (main_en),
    .wrap    (wrap),
    .slot    (slot),
    .setting (main_set),
    .gate_q  (main_gate),
    .lvl_q   (main_lvl)
  );

  // Auxiliary bank: analog step only, no period alignment needed.
  always_ff @(posedge clk) begin
    if (rst) begin
      aux_lvl <= '0;
    end else begin
      aux_lvl <= aux_en ? aux_code : 2'd0;
    end
  end
endmodule

// File: rtl/hybrid_brightness_enc_chk.sv
module hybrid_brightness_enc_chk #(
  parameter int SLOT_CYCLES = 391
) (
  input logic       clk,
  input logic       rst,
  input logic       main_en,
  input logic [4:0] main_code,
  input logic       aux_en,
  input logic [1:0] aux_code,
  input logic       main_gate,
  input logic [1:0] main_lvl,
  input logic [1:0] aux_lvl
);
  localparam int PERIOD = SLOT_CYCLES * 16;
  localparam int POS_W  = $clog2(PERIOD);

  logic [POS_W-1:0] pos;
  logic [1:0]       age;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
      age <= '0;
    end else begin
      pos <= (pos == POS_W'(PERIOD - 1)) ? '0 : pos + POS_W'(1);
      if (age != 2'd3) age <= age + 2'd1;
    end
  end

  // R8
  main_off_chk: assert property (@(posedge clk) disable iff (rst)
    !main_en |=> (!main_gate && main_lvl == 2'd0));

  // R9
  aux_on_chk: assert property (@(posedge clk) disable iff (rst)
    aux_en |=> (aux_lvl == $past(aux_code)));

  // R9
  aux_off_chk: assert property (@(posedge clk) disable iff (rst)
    !aux_en |=> (aux_lvl == 2'd0));

  // R7
  gate_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && $rose(main_gate)) |-> (pos == POS_W'(1)));

  // R7
  lvl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && pos != POS_W'(1) && $past(main_en) && $past(main_en, 2))
      |-> $stable(main_lvl));

  // R6
  slot_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && $fell(main_gate) && $past(main_en))
      |-> ((int'(pos) % SLOT_CYCLES) == (1 % SLOT_CYCLES)));
endmodule

bind hybrid_brightness_enc hybrid_brightness_enc_chk #(.SLOT_CYCLES(SLOT_CYCLES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .main_en   (main_en),
  .main_code (main_code),
  .aux_en    (aux_en),
  .aux_code  (aux_code),
  .main_gate (main_gate),
  .main_lvl  (main_lvl),
  .aux_lvl   (aux_lvl)
);

// File: tb/hybrid_brightness_enc_bench.sv
module hybrid_brightness_enc_bench;
  localparam int SC = 4;
  localparam int P  = SC * 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       main_en = 1'b0;
  logic [4:0] main_code = '0;
  logic       aux_en = 1'b0;
  logic [1:0] aux_code = '0;
  logic       main_gate;
  logic [1:0] main_lvl;
  logic [1:0] aux_lvl;

  int n_chk  = 0;
  int n_fail = 0;
  int cnt    = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (rst) cnt <= 0;
    else     cnt <= cnt + 1;
  end

  hybrid_brightness_enc #(.SLOT_CYCLES(SC)) u_hybrid_brightness_enc (
    .clk(clk), .rst(rst), .main_en(main_en), .main_code(main_code),
    .aux_en(aux_en), .aux_code(aux_code),
    .main_gate(main_gate), .main_lvl(main_lvl), .aux_lvl(aux_lvl)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_lvl(input int c);
    if (c <= 15) return 0;
    if (c <= 22) return 1;
    if (c <= 28) return 2;
    return 3;
  endfunction

  function automatic int exp_duty(input int c);
    if (c <= 15) return c + 1;
    if (c <= 22) return c - 6;
    if (c <= 28) return c - 12;
    if (c == 29) return 13;
    if (c == 30) return 15;
    return 16;
  endfunction

  function automatic string band_req(input int c);
    if (c <= 15) return "R2";
    if (c <= 22) return "R3";
    if (c <= 28) return "R4";
    return "R5";
  endfunction

  task automatic to_boundary();
    do @(negedge clk); while (cnt % P != 0);
  endtask

  // Sample one whole period right after a boundary edge.
  task automatic measure(input string req, input int lvl, input int duty);
    int bad_g = 0;
    int bad_l = 0;
    int high  = 0;
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      if (main_gate) high++;
      if (main_gate != (i < duty * SC)) bad_g++;
      if (int'(main_lvl) != lvl) bad_l++;
    end
    chk("R6", "gate slot pattern errors", bad_g, 0);
    chk("R6", "gate high cycles", high, duty * SC);
    chk(req, "level mismatches in period", bad_l, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1", "gate in reset", int'(main_gate), 0);
    chk("R1", "main level in reset", int'(main_lvl), 0);
    chk("R1", "aux level in reset", int'(aux_lvl), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "gate after reset", int'(main_gate), 0);
    chk("R1", "main level after reset", int'(main_lvl), 0);
  endtask

  task automatic t_sweep();
    for (int c = 0; c < 32; c++) begin
      main_en   = 1'b1;
      main_code = 5'(c);
      to_boundary();
      measure(band_req(c), exp_lvl(c), exp_duty(c));
    end
  endtask

  task automatic t_no_runt();
    int bad_g = 0;
    int bad_l = 0;
    main_code = 5'h03;
    to_boundary();
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      if (i == 20) main_code = 5'h1C;
      if (main_gate != (i < 4 * SC)) bad_g++;
      if (main_lvl != 2'd0) bad_l++;
    end
    chk("R7", "old-period gate errors after mid change", bad_g, 0);
    chk("R7", "old-period level errors after mid change", bad_l, 0);
    measure("R7", 2, 16);
  endtask

  task automatic t_disable();
    int bad = 0;
    main_code = 5'h1F;
    to_boundary();
    repeat (10) @(negedge clk);
    chk("R6", "full duty gate high", int'(main_gate), 1);
    main_en = 1'b0;
    @(negedge clk);
    chk("R8", "gate one clock after disable", int'(main_gate), 0);
    chk("R8", "level one clock after disable", int'(main_lvl), 0);
    to_boundary();
    measure("R8", 0, 0);
    while (cnt % P != P / 2) @(negedge clk);
    main_en = 1'b1;
    while (cnt % P != 0) begin
      @(negedge clk);
      if (main_gate || main_lvl != 2'd0) bad++;
    end
    chk("R7", "outputs before boundary after enable", bad, 0);
    measure("R7", 3, 16);
  endtask

  task automatic t_aux();
    for (int a = 0; a < 4; a++) begin
      int bad = 0;
      aux_en   = 1'b1;
      aux_code = 2'(a);
      @(negedge clk);
      chk("R9", "aux level one clock later", int'(aux_lvl), a);
      for (int i = 0; i < P + 8; i++) begin
        @(negedge clk);
        if (int'(aux_lvl) != a) bad++;
      end
      chk("R9", "aux level held without PWM", bad, 0);
    end
    aux_en = 1'b0;
    @(negedge clk);
    chk("R9", "aux level when disabled", int'(aux_lvl), 0);
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_no_runt();
    t_disable();
    t_aux();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule